// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

This block collects a serial bit stream into an 18-stage shift register. On command, it copies the whole register into a parallel holding latch. The serial data, the shift clock and the latch clock come from slow external sources. All three are brought into the system clock domain through two-flop synchronizers. A rising-edge detector on each synchronized clock turns every external edge into a single one-cycle event.

A small control interface sets two things. The first is the stage that drives the serial output tap. The second is whether the parallel latch contents reach the parallel output pins. A separate synchronous clear input empties both the register and the latch. The block suits pin expansion: software or a peripheral shifts in a pattern, then latches it onto many output lines at once. Both outputs are registered.

Top module: `latched_shift_reg`

## Requirements
- R1: Each shift clock rising edge moves the `ser_din` value into bit 0. Every other bit moves one stage toward bit 17, and the old bit 17 is lost.
- R2: Each latch clock rising edge copies all 18 register bits into the parallel latch.
- R3: When the shift and latch clocks rise together, the latch takes the register value from before that shift, so the latch trails by one bit.
- R4: `ser_dout` shows register bit N when the stored 5-bit tap value N is 0..17. It reads 0 when the stored tap value is 18..31.
- R5: While the stored enable is 0, `par_dout` reads all zeros. The latch still updates on latch clock edges, and the new contents show once the enable is set to 1.
- R6: While `sw_clear` is high, the register and the latch are zero. Shift and latch edges during that time have no effect.
- R7: A shift or latch clock held high for many system cycles counts as one edge only.
- R8: After reset, the register, latch, tap value and enable are all zero, so both outputs read 0.
- R9: The tap value and enable are loaded from `cfg_tap` and `cfg_en` only in cycles where `cfg_we` is 1. Otherwise they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_din | input | 1 | Serial data, asynchronous |
| shift_clk | input | 1 | Shift clock, asynchronous, rising edge active |
| latch_clk | input | 1 | Latch clock, asynchronous, rising edge active |
| sw_clear | input | 1 | Synchronous clear of register and latch |
| cfg_we | input | 1 | Load strobe for tap value and enable |
| cfg_tap | input | 5 | Serial output stage select |
| cfg_en | input | 1 | Parallel output enable |
| ser_dout | output | 1 | Selected register stage, registered |
| par_dout | output | 18 | Gated latch contents, registered |

## Verification
The assertions assume that every external clock level lasts at least two system cycles, so that the synchronizers deliver each level. They also assume that `ser_din` settles before the shift clock rises and holds until it falls. The bench meets both conditions: it changes inputs only on falling system edges and keeps every phase of a pulse three cycles long. It waits for the synchronizer, edge and output register delays to pass before it compares results with its own model of the register and latch.

// File: rtl/slr_pkg.sv
package slr_pkg;
  localparam int SLR_DEF_W = 18;
  localparam int SLR_DEF_SYNC = 2;

  typedef struct packed {
    logic shift;
    logic latch;
  } slr_evt_t;
endpackage

// File: rtl/slr_sync.sv
module slr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/slr_edge.sv
module slr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_det
      logic prev;
      always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else prev <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~prev;

      AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (rst)
        rise[i] |=> !rise[i]); // R7
    end
  endgenerate
endmodule

// File: rtl/slr_core.sv
module slr_core #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  slr_pkg::slr_evt_t ev,
  input  logic         din,
  output logic [W-1:0] sreg,
  output logic [W-1:0] hold
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sreg <= '0;
      hold <= '0;
    end else begin
      if (ev.shift) sreg <= {sreg[W-2:0], din};
      if (ev.latch) hold <= sreg;
    end
  end

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    (ev.shift && !clr) |=> sreg[W-1:1] == $past(sreg[W-2:0])); // R1
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ev.shift && !clr) |=> $stable(sreg)); // R7
  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
    (ev.latch && !clr) |=> hold == $past(sreg)); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ev.latch && !clr) |=> $stable(hold)); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (sreg == '0 && hold == '0)); // R6
endmodule

// File: rtl/slr_out.sv
module slr_out #(
  parameter int W = 18,
  localparam int TW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [TW-1:0] cfg_tap,
  input  logic          cfg_en,
  input  logic [W-1:0]  sreg,
  input  logic [W-1:0]  hold,
  output logic          ser_q,
  output logic [W-1:0]  par_q
);
  logic [TW-1:0] tap_q;
  logic          en_q;
  logic          tap_bit;
  logic          tap_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q <= '0;
      en_q  <= 1'b0;
    end else if (cfg_we) begin
      tap_q <= cfg_tap;
      en_q  <= cfg_en;
    end
  end

  always_comb begin
    tap_bit = 1'b0;
    tap_ok  = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (tap_q == TW'(i)) begin
        tap_bit = sreg[i];
        tap_ok  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_q <= 1'b0;
      par_q <= '0;
    end else begin
      ser_q <= tap_ok & tap_bit;
      par_q <= en_q ? hold : '0;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(tap_q) && $stable(en_q))); // R9
  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (tap_q > TW'(W-1)) |=> !ser_q); // R4
  AST_PAR_GATED: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> par_q == '0); // R5
endmodule

// File: rtl/latched_shift_reg.sv
module latched_shift_reg #(
  parameter int W     = slr_pkg::SLR_DEF_W,
  parameter int SYNC  = slr_pkg::SLR_DEF_SYNC,
  localparam int TW   = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_din,
  input  logic          shift_clk,
  input  logic          latch_clk,
  input  logic          sw_clear,
  input  logic          cfg_we,
  input  logic [TW-1:0] cfg_tap,
  input  logic          cfg_en,
  output logic          ser_dout,
  output logic [W-1:0]  par_dout
);
  logic [2:0]        raw_s;
  logic [1:0]        rise;
  slr_pkg::slr_evt_t ev;
  logic [W-1:0]      sreg;
  logic [W-1:0]      hold;

  slr_sync #(.WIDTH(3), .STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_din, latch_clk, shift_clk}),
    .q   (raw_s)
  );

  slr_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (raw_s[1:0]),
    .rise (rise)
  );

  assign ev.shift = rise[0];
  assign ev.latch = rise[1];

  slr_core #(.W(W)) u_core (
    .clk  (clk),
    .rst  (rst),
    .clr  (sw_clear),
    .ev   (ev),
    .din  (raw_s[2]),
    .sreg (sreg),
    .hold (hold)
  );

  slr_out #(.W(W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cfg_tap (cfg_tap),
    .cfg_en  (cfg_en),
    .sreg    (sreg),
    .hold    (hold),
    .ser_q   (ser_dout),
    .par_q   (par_dout)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    $past(rst) |-> (ser_dout == 1'b0 && par_dout == '0)); // R8
endmodule

// File: tb/sim_latched_shift_reg.sv
module sim_latched_shift_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_din = 1'b0, shift_clk = 1'b0, latch_clk = 1'b0, sw_clear = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0;
  logic [4:0] cfg_tap = '0;
  logic ser_dout;
  logic [W-1:0] par_dout;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  logic [W-1:0] m_sreg = '0, m_hold = '0;
  logic [4:0] m_tap = '0;
  logic m_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_shift_reg u0 (
    .clk(clk), .rst(rst), .ser_din(ser_din), .shift_clk(shift_clk),
    .latch_clk(latch_clk), .sw_clear(sw_clear), .cfg_we(cfg_we),
    .cfg_tap(cfg_tap), .cfg_en(cfg_en), .ser_dout(ser_dout), .par_dout(par_dout)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic f_tap(logic [W-1:0] s, logic [4:0] t);
    return (t < 5'(W)) ? s[t] : 1'b0;
  endfunction

  function automatic logic [W-1:0] f_par(logic [W-1:0] h, logic e);
    return e ? h : '0;
  endfunction

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_outs(string req);
    chk(req, {17'b0, ser_dout}, {17'b0, f_tap(m_sreg, m_tap)});
    chk(req, par_dout, f_par(m_hold, m_en));
  endtask

  task automatic pulse(bit do_sh, bit do_la, logic d);
    ser_din = d;
    wait_cyc(3);
    shift_clk = do_sh;
    latch_clk = do_la;
    wait_cyc(3);
    shift_clk = 1'b0;
    latch_clk = 1'b0;
    wait_cyc(3);
    if (do_la) m_hold = m_sreg;
    if (do_sh) m_sreg = {m_sreg[W-2:0], d};
  endtask

  task automatic cfg(logic [4:0] t, logic e);
    cfg_tap = t; cfg_en = e; cfg_we = 1'b1;
    wait_cyc(1);
    cfg_we = 1'b0;
    wait_cyc(3);
    m_tap = t; m_en = e;
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    // R8 reset state
    chk("R8", {17'b0, ser_dout}, '0);
    chk("R8", par_dout, '0);

    // R1 directed shift of a known pattern, then latch to observe
    cfg(5'd0, 1'b1);
    for (int i = 0; i < 20; i++) pulse(1'b1, 1'b0, 1'(i % 3 == 0));
    pulse(1'b0, 1'b1, 1'b0);
    chk("R1", par_dout, m_sreg);
    chk("R2", par_dout, m_hold);

    // R4 tap sweep including out of range values
    for (int t = 0; t < 32; t++) begin
      cfg(5'(t), 1'b1);
      chk(t < W ? "R4" : "R4 out-of-range", {17'b0, ser_dout}, {17'b0, f_tap(m_sreg, m_tap)});
    end

    // R3 both clocks rise together
    cfg(5'd0, 1'b1);
    pulse(1'b1, 1'b1, 1'b1);
    chk("R3", par_dout, m_hold);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R3 lag", par_dout, m_sreg);

    // R5 disabled output, latch keeps updating
    cfg(5'd3, 1'b0);
    pulse(1'b1, 1'b0, 1'b1);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R5 gated", par_dout, '0);
    cfg(5'd3, 1'b1);
    chk("R5 revealed", par_dout, m_hold);

    // R9 tap/enable ignored without write strobe
    cfg_tap = 5'd9; cfg_en = 1'b0;
    wait_cyc(4);
    chk("R9", par_dout, f_par(m_hold, 1'b1));
    chk("R9", {17'b0, ser_dout}, {17'b0, f_tap(m_sreg, 5'd3)});

    // R7 clock held high long: one shift only
    ser_din = 1'b1;
    wait_cyc(3);
    shift_clk = 1'b1;
    wait_cyc(40);
    shift_clk = 1'b0;
    wait_cyc(3);
    m_sreg = {m_sreg[W-2:0], 1'b1};
    pulse(1'b0, 1'b1, 1'b0);
    chk("R7", par_dout, m_sreg);

    // R6 clear overrides edges during clear
    sw_clear = 1'b1;
    pulse(1'b1, 1'b1, 1'b1);
    sw_clear = 1'b0;
    m_sreg = '0; m_hold = '0;
    wait_cyc(3);
    chk("R6", par_dout, '0);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R6 reg empty", par_dout, '0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int unsigned r = $urandom;
      if (r[3:0] == 4'd0) cfg(5'(r[8:4]), r[9]);
      else if (r[3:0] == 4'd1) begin
        cfg(5'(r[8:4] % 5'(W)), 1'b1);
        chk_outs("R4 random");
      end else begin
        pulse(r[10] | ~r[11], r[11], r[12]);
        chk_outs(r[11] ? "R2 random" : "R1 random");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule